// File: doc/BRIEF.md
# Acquisition Pacing and Sample-Count Controller

This block times a data-acquisition run for an analog converter. Once the host has armed it with an enable bit and written a start strobe, a sample-interval timer issues single-cycle conversion-start pulses. When several channels are scanned, a second timer decides when each scan may begin. A sample counter ends the run after the programmed number of conversions. Both timers count ticks of a base clock that the host picks from a chain of decade-divided rates. The fastest rate produces one tick every `TICK_DIV` system cycles, and each slower rate is ten times slower than the one before it.

The host presents its two command words and the timer settings as levels, and pulses strobes for start, result-FIFO clear and interrupt clear. The converter reports each finished result with a done pulse, and the host acknowledges it with a read pulse. The block answers with a 16-bit status word and a conversion-complete interrupt. The number of conversions is the number of scans times the number of entries per scan. It is counted on a 16-bit counter, or on a 32-bit counter built from two cascaded 16-bit halves.

Top module: `acq_pacer`

## Requirements
- R1: After reset, `status` is all zero and `conv_start` and `conv_irq` are low.
- R2: A start strobe starts a run only when enable bit 4 of `cmd1` is set and no run is in progress, and the busy flag is status bit 11. A strobe with the enable bit clear, or a strobe during a run, has no effect.
- R3: Clock-select code k (0 to 4) gives one tick every `TICK_DIV`·10^k cycles, counted from the start strobe. Codes 5 to 7 select the slowest rate. With reload R, the first conversion pulse comes R ticks after the start and the following pulses come every R ticks.
- R4: With clock code 0, a sample reload below 10 behaves as 10.
- R5: A run issues exactly `scan_count`·`scan_entries` pulses. Busy clears in the same cycle as the last pulse, and stop flag status bit 14 sets in that cycle.
- R6: With `cmd1` bit 1 clear, only the low 16 bits of the total are counted. With it set, the full 32-bit total is counted.
- R7: With `cmd1` bit 3 set and `scan_entries` of 2 or more, scan k begins k·(scan interval) after the start. Each scan gives `scan_entries` pulses at the sample interval, measured from the scan's beginning.
- R8: With `cmd1` bit 3 clear, pulses run back to back at the sample interval, whatever the entry count.
- R9: Clearing the enable bit during a run ends the run at once, with no further pulses and without setting the stop flag.
- R10: An interrupt-clear strobe clears the stop flag.
- R11: A converter done pulse sets result-available status bit 13, and a read pulse clears it. A done pulse while a result is still available sets overflow status bit 9. A clear strobe clears both bits.
- R12: `conv_irq` is high exactly while status bit 13, `cmd1` bit 7 and `cmd2` bit 7 are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd1 | input | 16 | Command word 1: bit 1 long count, bit 3 scan gating, bit 4 enable, bit 7 conversion interrupt |
| cmd2 | input | 16 | Command word 2: bit 7 global interrupt enable |
| start_strobe | input | 1 | Start-acquisition strobe |
| clear_strobe | input | 1 | Clears result-available and overflow |
| int_clear_strobe | input | 1 | Clears the stop flag |
| samp_clk_sel | input | 3 | Sample-timer clock code |
| samp_reload | input | 16 | Sample-timer reload in ticks |
| scan_clk_sel | input | 3 | Scan-timer clock code |
| scan_reload | input | 16 | Scan-timer reload in ticks |
| scan_count | input | 16 | Number of scans |
| scan_entries | input | 5 | Conversions per scan |
| conv_done | input | 1 | Converter result ready pulse |
| result_read | input | 1 | Host read of a result |
| conv_start | output | 1 | Conversion-start pulse |
| conv_irq | output | 1 | Conversion-complete interrupt |
| status | output | 16 | Status word: bits 9, 11, 13, 14 |

## Verification
A wrong internal count shows up directly as a shifted pulse time. The bench therefore records the exact cycle of every conversion pulse relative to the start strobe and compares it with arithmetic on the reload and the clock code. A drift in the tick chain or a timer off by one is seen at the first pulse, a miscount of the total is seen at the last pulse or in the busy flag, and a broken scan gate is seen at the first pulse of the second scan. Flag faults in the result-handling path are visible in the status word one cycle after the pulse that causes them.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam int NUM_CLK   = 5;
    localparam int MIN_TICKS = 10;
    // command word 1 fields
    localparam int C1_LONG = 1;
    localparam int C1_SCAN = 3;
    localparam int C1_ENA  = 4;
    localparam int C1_CINT = 7;
    // command word 2 fields
    localparam int C2_IEN  = 7;
    // status word fields
    localparam int ST_OVF   = 9;
    localparam int ST_BUSY  = 11;
    localparam int ST_AVAIL = 13;
    localparam int ST_STOP  = 14;
endpackage

// File: rtl/acq_tick_chain.sv
module acq_tick_chain #(
    parameter int TICK_DIV = 2,
    parameter int NCLK     = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    output logic [NCLK-1:0] tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [PW-1:0]              pre;
        logic [NCLK-2:0][3:0]       dec;
    } chain_t;

    chain_t st_d, st_q;

    assign tick[0] = run && (st_q.pre == PW'(TICK_DIV - 1));

    genvar k;
    generate
        for (k = 1; k < NCLK; k++) begin : g_dec
            assign tick[k] = tick[k-1] && (st_q.dec[k-1] == 4'd9);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '0;
        end else if (run) begin
            st_d.pre = tick[0] ? '0 : st_q.pre + PW'(1);
            for (int i = 0; i < NCLK - 1; i++) begin
                if (tick[i])
                    st_d.dec[i] = (st_q.dec[i] == 4'd9) ? 4'd0 : st_q.dec[i] + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/acq_interval_timer.sv
module acq_interval_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expire = tick && en && (cnt_q == W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = reload;
        else if (tick && en)
            cnt_d = expire ? reload : cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/acq_sample_counter.sv
module acq_sample_counter #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [2*HALF_W-1:0] total,
    input  logic                long_mode,
    input  logic                dec,
    output logic                last
);
    typedef struct packed {
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
    } cnt_t;

    cnt_t st_d, st_q;
    logic borrow;

    assign borrow = (st_q.lo == '0);
    assign last   = dec && (st_q.lo == HALF_W'(1)) && (st_q.hi == '0);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.lo = total[HALF_W-1:0];
            st_d.hi = long_mode ? total[2*HALF_W-1:HALF_W] : '0;
        end else if (dec) begin
            st_d.lo = st_q.lo - HALF_W'(1);
            if (borrow)
                st_d.hi = st_q.hi - HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer
    import acq_pkg::*;
#(
    parameter int TICK_DIV = 2,
    parameter int RW       = 16,
    parameter int ENTRY_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cmd1,
    input  logic [15:0]        cmd2,
    input  logic               start_strobe,
    input  logic               clear_strobe,
    input  logic               int_clear_strobe,
    input  logic [2:0]         samp_clk_sel,
    input  logic [RW-1:0]      samp_reload,
    input  logic [2:0]         scan_clk_sel,
    input  logic [RW-1:0]      scan_reload,
    input  logic [RW-1:0]      scan_count,
    input  logic [ENTRY_W-1:0] scan_entries,
    input  logic               conv_done,
    input  logic               result_read,
    output logic               conv_start,
    output logic               conv_irq,
    output logic [15:0]        status
);
    localparam int TW = 2 * RW;

    typedef struct packed {
        logic               running;
        logic               scan_active;
        logic [ENTRY_W-1:0] scan_left;
        logic               conv;
        logic               stop;
        logic               avail;
        logic               ovf;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_CLK-1:0] ticks;
    logic start_go, cancel, scanning;
    logic samp_tick, scan_tick;
    logic samp_en, scan_en, samp_load;
    logic fire, scan_expire, scan_end, scan_begin, last;
    logic [RW-1:0] samp_eff;
    logic [TW-1:0] total;
    logic unused_cmd;

    assign unused_cmd = ^{cmd1[15:8], cmd1[6:5], cmd1[2], cmd1[0], cmd2[15:8], cmd2[6:0]};

    function automatic logic pick_tick(input logic [2:0] sel, input logic [NUM_CLK-1:0] t);
        if (int'(sel) >= NUM_CLK) return t[NUM_CLK-1];
        return t[sel];
    endfunction

    assign start_go  = start_strobe && cmd1[C1_ENA] && !st_q.running;
    assign cancel    = st_q.running && !cmd1[C1_ENA];
    assign scanning  = cmd1[C1_SCAN] && (scan_entries > ENTRY_W'(1));
    assign samp_tick = pick_tick(samp_clk_sel, ticks);
    assign scan_tick = pick_tick(scan_clk_sel, ticks);
    assign samp_eff  = ((samp_clk_sel == 3'd0) && (samp_reload < RW'(MIN_TICKS)))
                       ? RW'(MIN_TICKS) : samp_reload;
    assign samp_en   = st_q.running && (!scanning || st_q.scan_active);
    assign scan_en   = st_q.running && scanning;
    assign scan_end  = fire && scanning && (st_q.scan_left == ENTRY_W'(1));
    assign scan_begin = scan_expire && (!st_q.scan_active || scan_end);
    assign samp_load = start_go || scan_begin;
    assign total     = TW'(scan_count) * TW'(scan_entries);

    acq_tick_chain #(.TICK_DIV(TICK_DIV), .NCLK(NUM_CLK)) u_ticks (
        .clk(clk), .rst_n(rst_n), .restart(start_go), .run(st_q.running), .tick(ticks)
    );

    acq_interval_timer #(.W(RW)) u_samp_tmr (
        .clk(clk), .rst_n(rst_n), .tick(samp_tick), .en(samp_en),
        .load(samp_load), .reload(samp_eff), .expire(fire)
    );

    acq_interval_timer #(.W(RW)) u_scan_tmr (
        .clk(clk), .rst_n(rst_n), .tick(scan_tick), .en(scan_en),
        .load(start_go), .reload(scan_reload), .expire(scan_expire)
    );

    acq_sample_counter #(.HALF_W(RW)) u_count (
        .clk(clk), .rst_n(rst_n), .load(start_go), .total(total),
        .long_mode(cmd1[C1_LONG]), .dec(fire), .last(last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.conv = 1'b0;
        if (start_go) begin
            st_d.running     = 1'b1;
            st_d.scan_active = 1'b1;
            st_d.scan_left   = scan_entries;
        end
        if (fire) begin
            st_d.conv = 1'b1;
            if (scan_end)      st_d.scan_active = 1'b0;
            else if (scanning) st_d.scan_left   = st_q.scan_left - ENTRY_W'(1);
        end
        if (scan_begin) begin
            st_d.scan_active = 1'b1;
            st_d.scan_left   = scan_entries;
        end
        if (int_clear_strobe) st_d.stop = 1'b0;
        if (last) begin
            st_d.running     = 1'b0;
            st_d.scan_active = 1'b0;
            st_d.stop        = 1'b1;
        end
        if (cancel) begin
            st_d.running     = 1'b0;
            st_d.scan_active = 1'b0;
        end
        // result handling
        if (conv_done && st_q.avail && !result_read) st_d.ovf = 1'b1;
        if (result_read) st_d.avail = 1'b0;
        if (conv_done)   st_d.avail = 1'b1;
        if (clear_strobe) begin
            st_d.avail = 1'b0;
            st_d.ovf   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status           = '0;
        status[ST_OVF]   = st_q.ovf;
        status[ST_BUSY]  = st_q.running;
        status[ST_AVAIL] = st_q.avail;
        status[ST_STOP]  = st_q.stop;
    end

    assign conv_start = st_q.conv;
    assign conv_irq   = st_q.avail && cmd1[C1_CINT] && cmd2[C2_IEN];
endmodule

// File: rtl/acq_pacer_chk.sv
module acq_pacer_chk (
    input logic clk,
    input logic rst_n,
    input logic start_strobe,
    input logic ena,
    input logic conv_start,
    input logic busy,
    input logic stop,
    input logic avail,
    input logic ovf
);
    // R2
    busy_needs_armed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_strobe && ena));
    // R5
    stop_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop) |-> $fell(busy));
    // R3
    pulse_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(busy));
    // R4
    pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R11
    overflow_after_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(avail));
endmodule

bind acq_pacer acq_pacer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_strobe(start_strobe), .ena(cmd1[4]),
    .conv_start(conv_start), .busy(status[11]), .stop(status[14]),
    .avail(status[13]), .ovf(status[9])
);

// File: tb/acq_pacer_test.sv
module acq_pacer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cmd1 = '0, cmd2 = '0;
    logic start_strobe = 0, clear_strobe = 0, int_clear_strobe = 0;
    logic [2:0] samp_clk_sel = '0, scan_clk_sel = '0;
    logic [15:0] samp_reload = '0, scan_reload = '0, scan_count = '0;
    logic [4:0] scan_entries = '0;
    logic conv_done = 0, result_read = 0;
    logic conv_start, conv_irq;
    logic [15:0] status;

    int checks = 0, errors = 0;
    int times[64];
    int nconv;

    always #5 clk = ~clk;

    acq_pacer uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk1(bit lng, bit scn, bit ena, bit cint);
        logic [15:0] v = '0;
        v[1] = lng; v[3] = scn; v[4] = ena; v[7] = cint;
        return v;
    endfunction

    // starts a run and logs the cycle number of every conversion pulse
    task automatic capture(input int max_cyc, input int stop_after, input int restrobe_at);
        int c = 0;
        nconv = 0;
        @(negedge clk);
        start_strobe = 1;
        while (c < max_cyc) begin
            @(negedge clk);
            start_strobe = 0;
            c++;
            if (c == restrobe_at) start_strobe = 1;
            if (conv_start && nconv < 64) begin
                times[nconv] = c;
                nconv++;
            end
            if (!status[11]) break;
            if (stop_after > 0 && nconv == stop_after) break;
        end
        start_strobe = 0;
    endtask

    task automatic check_plain(input string req, input int n, input int first, input int step);
        chk(nconv == n, req, nconv, n);
        for (int i = 0; i < n && i < nconv; i++)
            chk(times[i] == first + i * step, req, times[i], first + i * step);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status == 16'h0, "R1", status, 0);
        chk(conv_start == 0 && conv_irq == 0, "R1", conv_start, 0);
        rst_n = 1;
        @(negedge clk);

        // R3/R5 single channel, code 0 reload 12: 24-cycle spacing, restrobe ignored (R2)
        cmd1 = mk1(0, 0, 1, 0);
        samp_clk_sel = 0; samp_reload = 12; scan_count = 5; scan_entries = 1;
        capture(2000, 0, 30);
        check_plain("R3", 5, 25, 24);
        chk(status[11] == 0, "R5", status[11], 0);
        chk(status[14] == 1, "R5", status[14], 1);
        // R10 interrupt clear
        @(negedge clk); int_clear_strobe = 1;
        @(negedge clk); int_clear_strobe = 0;
        chk(status[14] == 0, "R10", status[14], 0);

        // R4 clamp
        samp_reload = 3; scan_count = 3;
        capture(2000, 0, 0);
        check_plain("R4", 3, 21, 20);

        // R3 decade codes 1 and 2, and out-of-range code
        samp_clk_sel = 1; samp_reload = 2; scan_count = 2;
        capture(2000, 0, 0);
        check_plain("R3", 2, 41, 40);
        samp_clk_sel = 2; samp_reload = 1;
        capture(2000, 0, 0);
        check_plain("R3", 2, 201, 200);
        samp_clk_sel = 7; samp_reload = 1; scan_count = 1;
        capture(30000, 0, 0);
        check_plain("R3", 1, 20001, 0);

        // R7 scan gating: 3 entries at 20 cycles, scans every 100 cycles
        cmd1 = mk1(0, 1, 1, 0);
        samp_clk_sel = 0; samp_reload = 10;
        scan_clk_sel = 1; scan_reload = 5; scan_count = 2; scan_entries = 3;
        capture(2000, 0, 0);
        chk(nconv == 6, "R7", nconv, 6);
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 3; i++)
                if (k * 3 + i < nconv)
                    chk(times[k*3+i] == k*100 + (i+1)*20 + 1, "R7", times[k*3+i], k*100 + (i+1)*20 + 1);

        // R8 gating off: continuous, total still scans times entries (R5)
        cmd1 = mk1(0, 0, 1, 0);
        capture(2000, 0, 0);
        check_plain("R8", 6, 21, 20);

        // R6 short mode truncates 16385*4 = 65540 to 4
        scan_count = 16385; scan_entries = 4;
        capture(2000, 0, 0);
        check_plain("R6", 4, 21, 20);
        @(negedge clk); int_clear_strobe = 1;
        @(negedge clk); int_clear_strobe = 0;

        // R6 long mode keeps counting, then R9 cancel
        cmd1 = mk1(1, 0, 1, 0);
        capture(2000, 6, 0);
        check_plain("R6", 6, 21, 20);
        chk(status[11] == 1, "R6", status[11], 1);
        cmd1 = mk1(1, 0, 0, 0);
        @(negedge clk);
        chk(status[11] == 0, "R9", status[11], 1'b0);
        begin
            int pulses = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (conv_start) pulses++;
            end
            chk(pulses == 0, "R9", pulses, 0);
        end
        chk(status[14] == 0, "R9", status[14], 0);

        // R2 start with enable clear is ignored
        @(negedge clk); start_strobe = 1;
        @(negedge clk); start_strobe = 0;
        begin
            int pulses = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (conv_start || status[11]) pulses++;
            end
            chk(pulses == 0, "R2", pulses, 0);
        end

        // R11 / R12 result flags and interrupt
        cmd1 = mk1(0, 0, 0, 1); cmd2 = 16'h0000;
        @(negedge clk); conv_done = 1;
        @(negedge clk); conv_done = 0;
        chk(status[13] == 1, "R11", status[13], 1);
        chk(conv_irq == 0, "R12", conv_irq, 0);
        cmd2 = 16'h0080;
        @(negedge clk);
        chk(conv_irq == 1, "R12", conv_irq, 1);
        cmd1 = mk1(0, 0, 0, 0);
        @(negedge clk);
        chk(conv_irq == 0, "R12", conv_irq, 0);
        result_read = 1;
        @(negedge clk); result_read = 0;
        chk(status[13] == 0, "R11", status[13], 0);
        chk(status[9] == 0, "R11", status[9], 0);
        conv_done = 1;
        @(negedge clk);
        @(negedge clk); conv_done = 0;
        chk(status[9] == 1, "R11", status[9], 1);
        clear_strobe = 1;
        @(negedge clk); clear_strobe = 0;
        chk(status[9] == 0 && status[13] == 0, "R11", status[13], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule